// File: doc/BRIEF.md
# Shared Display Memory Scanner and Host Arbiter

This block owns a dynamic display memory that holds a frame of X/Y sample pairs. On a frame request it walks the memory from address zero upward, one access per sample, and streams each word out as an X half and a Y half for the deflection path. The scan reads every address in order, so the memory stays refreshed while a frame is being drawn and no separate refresh cycle is needed. When the last sample of a frame has been read, the block raises an interrupt and goes idle until the next frame request.

A host processor can ask for the memory with a request line. The request is granted only when no frame is being scanned, and it wins over a pending frame request. The grant is an active-low enable. While the host holds the grant, its address, write strobe and write data set up one memory access. The row and column strobes for that access still come from this block, with the same timing as a scan access.

Each access has four steps. The row address is presented with the row strobe low. Next the column address is presented. The column strobe is then held low for a fixed number of clocks. Finally both strobes return high for a precharge period.

Top module: `disp_ram_scanner`

## Requirements
- R1: While reset is low and on the first clock after it, both memory strobes and the memory write enable are high, the host enable is high, and scan_busy, frame_irq and sample_valid are low.
- R2: A frame_req pulse seen while idle with no host request sets scan_busy on the next clock. The frame then yields exactly FRAME_LEN sample_valid pulses, read from addresses 0 to FRAME_LEN-1 in ascending order. sample_x is the upper half of each word and sample_y is the lower half. sample_valid is never high outside a scan.
- R3: Every access holds the row strobe low with the row address (upper ROW_W address bits) for one clock, then with the column address (lower COL_W bits) for one clock. The column strobe then goes low for CAS_CYC clocks. Both strobes then stay high for at least PRE_CYC clocks. The column strobe is never low while the row strobe is high.
- R4: During a scan the memory write enable stays high and the host enable stays high.
- R5: frame_irq rises in the same cycle that scan_busy falls at the end of a frame. It holds until a frame request is accepted, and it is low in the first cycle of the next scan.
- R6: A frame_req pulse that arrives during a scan is ignored. After that frame ends, the block stays idle with frame_irq high.
- R7: A host request that arrives during a scan is not granted until the scan ends. It is then granted before any further frame starts.
- R8: A granted host write stores host_wdata at host_addr. A granted host read returns the word at host_addr on host_rdata in the cycle that host_done pulses. The memory write enable goes low only during the column-strobe phase of a host write.
- R9: A host access uses the same strobe timing as a scan access, driven by this block, with the host's row and column bits on ram_addr.
- R10: A frame_req that arrives together with a host request, or during a host access, is remembered. The frame starts one idle cycle after the host access ends, without a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_req | input | 1 | Request for the next frame scan |
| frame_irq | output | 1 | Frame finished, waiting for a request |
| scan_busy | output | 1 | High while a frame is being scanned |
| host_req | input | 1 | Host asks for one memory access |
| host_we | input | 1 | Host access is a write |
| host_addr | input | ROW_W+COL_W | Host word address, row bits on top |
| host_wdata | input | DATA_W | Host write data |
| host_en_n | output | 1 | Active-low host grant |
| host_done | output | 1 | Host access completes this cycle |
| host_rdata | output | DATA_W | Host read data |
| sample_valid | output | 1 | Sample pair valid |
| sample_x | output | DATA_W/2 | X sample (upper half of word) |
| sample_y | output | DATA_W/2 | Y sample (lower half of word) |
| ram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Memory write enable, active low |
| ram_wdata | output | DATA_W | Memory write data |
| ram_rdata | input | DATA_W | Memory read data |

## Verification
Two collisions matter. The first is a host request and a frame request in the same idle cycle. The bench raises both together and expects the host access to finish before scan_busy rises, with the frame starting by itself afterwards. The second is a host request and a second frame request that arrive while a frame is still running. The bench checks that the host enable stays high up to the end-of-frame cycle, that the host is then served, and that the block stays idle with the interrupt set. Memory contents are filled at random and overwritten by random host writes. Every streamed sample is compared against a shadow copy kept by the bench.

// File: rtl/disp_scan_pkg.sv
// Shared types for the display memory scanner.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package disp_scan_pkg;

    // Owner of the memory at the arbitration level
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_SCAN = 2'd1,
        ARB_HOST = 2'd2
    } arb_state_t;

    // Phase of one row/column access
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_ROW  = 3'd1,
        PH_COL  = 3'd2,
        PH_CAS  = 3'd3,
        PH_PRE  = 3'd4
    } acc_phase_t;

endpackage

// File: rtl/dram_cycle_engine.sv
// Runs one row/column access on the dynamic memory per start pulse.
// Sequence: row strobe low with row address (1 clk), column address
// (1 clk), column strobe low CAS_CYC clks, both high PRE_CYC clks.
// Assumes: start is only raised while eng_idle; CAS_CYC and PRE_CYC >= 1.
module dram_cycle_engine
    import disp_scan_pkg::*;
#(
    parameter int ROW_W   = 8,
    parameter int COL_W   = 8,
    parameter int DATA_W  = 16,
    parameter int CAS_CYC = 2,
    parameter int PRE_CYC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [ROW_W+COL_W-1:0]   start_addr,
    input  logic                     start_we,
    input  logic [DATA_W-1:0]        start_wdata,
    output logic                     eng_idle,
    output logic                     eng_done,
    output logic                     rd_valid,
    output logic [DATA_W-1:0]        rd_data,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] ram_addr,
    output logic                     ram_ras_n,
    output logic                     ram_cas_n,
    output logic                     ram_we_n,
    output logic [DATA_W-1:0]        ram_wdata,
    input  logic [DATA_W-1:0]        ram_rdata
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int T_MAX  = (CAS_CYC > PRE_CYC) ? CAS_CYC : PRE_CYC;
    localparam int TCNT_W = $clog2(T_MAX + 1);

    acc_phase_t         phase_q;
    logic [TCNT_W-1:0]  tcnt_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               we_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rd_data_q;
    logic               rd_valid_q;

    // Phase sequencer, operand latch and read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            tcnt_q     <= '0;
            addr_q     <= '0;
            we_q       <= 1'b0;
            wdata_q    <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        addr_q  <= start_addr;
                        we_q    <= start_we;
                        wdata_q <= start_wdata;
                        phase_q <= PH_ROW;
                    end
                end
                PH_ROW: phase_q <= PH_COL;
                PH_COL: begin
                    phase_q <= PH_CAS;
                    tcnt_q  <= TCNT_W'(CAS_CYC - 1);
                end
                PH_CAS: begin
                    if (tcnt_q == '0) begin
                        if (!we_q) begin
                            rd_data_q  <= ram_rdata;
                            rd_valid_q <= 1'b1;
                        end
                        phase_q <= PH_PRE;
                        tcnt_q  <= TCNT_W'(PRE_CYC - 1);
                    end else begin
                        tcnt_q <= tcnt_q - 1'b1;
                    end
                end
                PH_PRE: begin
                    if (tcnt_q == '0) phase_q <= PH_IDLE;
                    else              tcnt_q  <= tcnt_q - 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Strobe and address decode from the current phase
    always_comb begin
        ram_ras_n = !(phase_q == PH_ROW || phase_q == PH_COL || phase_q == PH_CAS);
        ram_cas_n = (phase_q != PH_CAS);
        ram_we_n  = !(phase_q == PH_CAS && we_q);
        if (phase_q == PH_ROW) ram_addr = MUX_W'(addr_q[ADDR_W-1:COL_W]);
        else                   ram_addr = MUX_W'(addr_q[COL_W-1:0]);
    end

    assign ram_wdata = wdata_q;
    assign eng_idle  = (phase_q == PH_IDLE);
    assign eng_done  = (phase_q == PH_PRE) && (tcnt_q == '0);
    assign rd_valid  = rd_valid_q;
    assign rd_data   = rd_data_q;

endmodule

// File: rtl/scan_addr_counter.sv
// Ascending scan address for one frame, cleared at frame start.
// Assumes: FRAME_LEN <= 2**ADDR_W and FRAME_LEN >= 1.
module scan_addr_counter #(
    parameter int ADDR_W    = 16,
    parameter int FRAME_LEN = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(FRAME_LEN - 1);

    logic [ADDR_W-1:0] addr_q;

    // Address register: clear on frame start, step after each access
    always_ff @(posedge clk) begin
        if (!rst_n)   addr_q <= '0;
        else if (clr) addr_q <= '0;
        else if (adv) addr_q <= addr_q + 1'b1;
    end

    assign addr = addr_q;
    assign last = (addr_q == LAST_ADDR);

endmodule

// File: rtl/disp_ram_arbiter.sv
// Decides who owns the memory: idle, frame scan or one host access.
// Host requests win over frame requests in idle; frame requests seen
// during a host access are kept pending; during a scan they are dropped.
// Assumes: eng_done pulses once per access.
module disp_ram_arbiter
    import disp_scan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_req,
    input  logic       host_req,
    input  logic       eng_done,
    input  logic       scan_last,
    output arb_state_t state,
    output logic       frame_start,
    output logic       frame_irq
);
    arb_state_t state_q;
    logic       pend_q;
    logic       irq_q;

    // Frame start condition seen from idle
    assign frame_start = (state_q == ARB_IDLE) && !host_req && (pend_q || frame_req);

    // Ownership state, pending frame flag and interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            pend_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            case (state_q)
                ARB_IDLE: begin
                    if (host_req) begin
                        state_q <= ARB_HOST;
                        if (frame_req) pend_q <= 1'b1;
                    end else if (frame_start) begin
                        state_q <= ARB_SCAN;
                        pend_q  <= 1'b0;
                        irq_q   <= 1'b0;
                    end
                end
                ARB_SCAN: begin
                    if (eng_done && scan_last) begin
                        state_q <= ARB_IDLE;
                        irq_q   <= 1'b1;
                    end
                end
                ARB_HOST: begin
                    if (frame_req) pend_q <= 1'b1;
                    if (eng_done)  state_q <= ARB_IDLE;
                end
                default: state_q <= ARB_IDLE;
            endcase
        end
    end

    assign state     = state_q;
    assign frame_irq = irq_q;

endmodule

// File: rtl/disp_ram_scanner.sv
// Top of the display memory scanner: arbitration, scan address, access
// engine and the output split of each word into X and Y samples.
// Assumes: DATA_W is even; the host holds host_req, host_we, host_addr
// and host_wdata steady until host_done and drops host_req after it.
module disp_ram_scanner
    import disp_scan_pkg::*;
#(
    parameter int ROW_W     = 8,
    parameter int COL_W     = 8,
    parameter int DATA_W    = 16,
    parameter int FRAME_LEN = 1024,
    parameter int CAS_CYC   = 2,
    parameter int PRE_CYC   = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_req,
    output logic                     frame_irq,
    output logic                     scan_busy,
    input  logic                     host_req,
    input  logic                     host_we,
    input  logic [ROW_W+COL_W-1:0]   host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic                     host_en_n,
    output logic                     host_done,
    output logic [DATA_W-1:0]        host_rdata,
    output logic                     sample_valid,
    output logic [DATA_W/2-1:0]      sample_x,
    output logic [DATA_W/2-1:0]      sample_y,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] ram_addr,
    output logic                     ram_ras_n,
    output logic                     ram_cas_n,
    output logic                     ram_we_n,
    output logic [DATA_W-1:0]        ram_wdata,
    input  logic [DATA_W-1:0]        ram_rdata
);
    localparam int ADDR_W   = ROW_W + COL_W;
    localparam int SAMPLE_W = DATA_W / 2;

    arb_state_t         state;
    logic               frame_start;
    logic               eng_idle;
    logic               eng_done;
    logic               eng_start;
    logic               rd_valid;
    logic [DATA_W-1:0]  rd_data;
    logic [ADDR_W-1:0]  scan_addr;
    logic               scan_last;
    logic [ADDR_W-1:0]  acc_addr;
    logic               is_scan;
    logic               is_host;

    disp_ram_arbiter u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_req   (frame_req),
        .host_req    (host_req),
        .eng_done    (eng_done),
        .scan_last   (scan_last),
        .state       (state),
        .frame_start (frame_start),
        .frame_irq   (frame_irq)
    );

    scan_addr_counter #(
        .ADDR_W    (ADDR_W),
        .FRAME_LEN (FRAME_LEN)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (frame_start),
        .adv   (is_scan && eng_done),
        .addr  (scan_addr),
        .last  (scan_last)
    );

    // Owner flags and access launch whenever an owner exists and the engine rests
    always_comb begin
        is_scan   = (state == ARB_SCAN);
        is_host   = (state == ARB_HOST);
        eng_start = (is_scan || is_host) && eng_idle;
        acc_addr  = is_host ? host_addr : scan_addr;
    end

    dram_cycle_engine #(
        .ROW_W   (ROW_W),
        .COL_W   (COL_W),
        .DATA_W  (DATA_W),
        .CAS_CYC (CAS_CYC),
        .PRE_CYC (PRE_CYC)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (eng_start),
        .start_addr  (acc_addr),
        .start_we    (is_host && host_we),
        .start_wdata (host_wdata),
        .eng_idle    (eng_idle),
        .eng_done    (eng_done),
        .rd_valid    (rd_valid),
        .rd_data     (rd_data),
        .ram_addr    (ram_addr),
        .ram_ras_n   (ram_ras_n),
        .ram_cas_n   (ram_cas_n),
        .ram_we_n    (ram_we_n),
        .ram_wdata   (ram_wdata),
        .ram_rdata   (ram_rdata)
    );

    assign scan_busy    = is_scan;
    assign host_en_n    = !is_host;
    assign host_done    = is_host && eng_done;
    assign host_rdata   = rd_data;
    assign sample_valid = is_scan && rd_valid;
    assign sample_x     = rd_data[DATA_W-1 -: SAMPLE_W];
    assign sample_y     = rd_data[SAMPLE_W-1:0];

endmodule

// File: rtl/disp_ram_scanner_chk.sv
// Temporal checks on the scanner's ports, bound to every instance.
// Assumes: CAS_CYC below 255.
module disp_ram_scanner_chk #(
    parameter int CAS_CYC = 2
) (
    input logic clk,
    input logic rst_n,
    input logic ram_ras_n,
    input logic ram_cas_n,
    input logic ram_we_n,
    input logic scan_busy,
    input logic host_en_n,
    input logic frame_irq,
    input logic sample_valid
);
    logic [7:0] cas_run_q;

    // Length of the current column-strobe low run
    always_ff @(posedge clk) begin
        if (!rst_n)          cas_run_q <= '0;
        else if (ram_cas_n)  cas_run_q <= '0;
        else if (cas_run_q != 8'hFF) cas_run_q <= cas_run_q + 1'b1;
    end

    // R3
    cas_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cas_n |-> !ram_ras_n);
    // R3
    cas_after_two_row_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_cas_n) |-> (!$past(ram_ras_n) && !$past(ram_ras_n, 2)));
    // R3
    cas_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cas_n |-> (cas_run_q < 8'(CAS_CYC)));
    // R4
    scan_read_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy |-> (ram_we_n && host_en_n));
    // R8
    write_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> (!host_en_n && !ram_cas_n));
    // R5
    irq_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_busy) |-> frame_irq);
    // R5
    irq_clear_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_busy) |-> !frame_irq);
    // R7
    grant_not_from_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_en_n) |-> !$past(scan_busy));
    // R2
    sample_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |-> scan_busy);

endmodule

bind disp_ram_scanner disp_ram_scanner_chk #(.CAS_CYC(CAS_CYC)) u_scan_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ram_ras_n    (ram_ras_n),
    .ram_cas_n    (ram_cas_n),
    .ram_we_n     (ram_we_n),
    .scan_busy    (scan_busy),
    .host_en_n    (host_en_n),
    .frame_irq    (frame_irq),
    .sample_valid (sample_valid)
);

// File: tb/tb_disp_ram_scanner.sv
// Bench: behavioural dynamic memory, random contents and host traffic,
// directed collisions of host and frame requests.
module tb_disp_ram_scanner;
    localparam int ROW_W   = 4;
    localparam int COL_W   = 4;
    localparam int DATA_W  = 16;
    localparam int FLEN    = 64;
    localparam int CAS_CYC = 2;
    localparam int PRE_CYC = 2;
    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int DEPTH   = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_req = 1'b0;
    logic host_req = 1'b0;
    logic host_we = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic frame_irq, scan_busy, host_en_n, host_done, sample_valid;
    logic [DATA_W-1:0] host_rdata, ram_wdata, ram_rdata;
    logic [DATA_W/2-1:0] sample_x, sample_y;
    logic [3:0] ram_addr;
    logic ram_ras_n, ram_cas_n, ram_we_n;

    int checks = 0;
    int fails = 0;
    int sample_idx = 0;
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] shadow [DEPTH];
    logic [ROW_W-1:0] m_row = '0;
    logic [COL_W-1:0] m_col = '0;
    logic ras_prev = 1'b1, cas_prev = 1'b1;
    int ras_cnt = 0, cas_cnt = 0, pre_cnt = 100;

    always #2 clk = ~clk;

    disp_ram_scanner #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .FRAME_LEN(FLEN), .CAS_CYC(CAS_CYC), .PRE_CYC(PRE_CYC)
    ) dut (
        .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .frame_irq(frame_irq),
        .scan_busy(scan_busy), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_en_n(host_en_n),
        .host_done(host_done), .host_rdata(host_rdata), .sample_valid(sample_valid),
        .sample_x(sample_x), .sample_y(sample_y), .ram_addr(ram_addr),
        .ram_ras_n(ram_ras_n), .ram_cas_n(ram_cas_n), .ram_we_n(ram_we_n),
        .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    assign ram_rdata = mem[{m_row, m_col}];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] exp_word(input int a);
        return shadow[a];
    endfunction

    // Memory model, strobe timing monitor and sample checker
    always @(negedge clk) begin
        if (!ram_ras_n && ras_prev) begin
            m_row <= ram_addr[ROW_W-1:0];
            check(pre_cnt >= PRE_CYC, "R3 precharge", pre_cnt, PRE_CYC);
        end
        if (!ram_cas_n && cas_prev) begin
            m_col = ram_addr[COL_W-1:0];
            if (!ram_we_n) mem[{m_row, ram_addr[COL_W-1:0]}] = ram_wdata;
        end
        if (!ram_ras_n) begin ras_cnt++; pre_cnt = 0; end
        else pre_cnt++;
        if (!ram_cas_n) cas_cnt++;
        if (ram_ras_n && !ras_prev) begin
            check(ras_cnt == 2 + CAS_CYC, "R3 row strobe length", ras_cnt, 2 + CAS_CYC);
            check(cas_cnt == CAS_CYC, "R3 column strobe length", cas_cnt, CAS_CYC);
            ras_cnt = 0; cas_cnt = 0;
        end
        ras_prev <= ram_ras_n;
        cas_prev <= ram_cas_n;
        if (rst_n && scan_busy)
            check(ram_we_n && host_en_n, "R4 scan read only", {ram_we_n, host_en_n}, 2'b11);
        if (rst_n && sample_valid) begin
            check(sample_idx < FLEN, "R2 sample count", sample_idx, FLEN - 1);
            if (sample_idx < FLEN)
                check({sample_x, sample_y} == exp_word(sample_idx), "R2 sample order/split",
                      {sample_x, sample_y}, exp_word(sample_idx));
            sample_idx++;
        end
    end

    task automatic host_access(input bit we, input logic [ADDR_W-1:0] a,
                               input logic [DATA_W-1:0] d, output logic [DATA_W-1:0] rd);
        @(negedge clk);
        host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
        @(negedge clk);
        while (!host_done) @(negedge clk);
        check(!host_en_n, "R8 grant during access", host_en_n, 0);
        rd = host_rdata;
        host_req = 1'b0;
        if (we) shadow[a] = d;
    endtask

    task automatic wait_frame_end();
        while (scan_busy) @(negedge clk);
        check(frame_irq, "R5 irq at frame end", frame_irq, 1);
        check(sample_idx == FLEN, "R2 frame length", sample_idx, FLEN);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] rd;
        void'($urandom(32'd777));
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = DATA_W'($urandom);
            shadow[i] = mem[i];
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check({ram_ras_n, ram_cas_n, ram_we_n, host_en_n} == 4'hF, "R1 strobes idle",
              {ram_ras_n, ram_cas_n, ram_we_n, host_en_n}, 4'hF);
        check({scan_busy, frame_irq, sample_valid} == 3'b0, "R1 flags low",
              {scan_busy, frame_irq, sample_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({scan_busy, frame_irq, host_en_n} == 3'b001, "R1 after release",
              {scan_busy, frame_irq, host_en_n}, 3'b001);

        // R8 R9 random host writes including corner addresses, then reads
        void'(host_access(1'b1, '0, 16'hA5C3, rd));
        host_access(1'b1, ADDR_W'(DEPTH - 1), 16'h3C5A, rd);
        host_access(1'b1, ADDR_W'(FLEN - 1), 16'h0FF0, rd);
        for (int i = 0; i < 40; i++)
            host_access(1'b1, ADDR_W'($urandom % DEPTH), DATA_W'($urandom), rd);
        for (int i = 0; i < 12; i++) begin
            logic [ADDR_W-1:0] a;
            a = (i == 0) ? ADDR_W'(DEPTH - 1) : ADDR_W'($urandom % DEPTH);
            host_access(1'b0, a, '0, rd);
            check(rd == shadow[a], "R8 R9 host read", rd, shadow[a]);
        end

        // R2 R5 plain frame
        sample_idx = 0;
        @(negedge clk); frame_req = 1'b1;
        @(negedge clk); frame_req = 1'b0;
        check(scan_busy, "R2 scan starts next clock", scan_busy, 1);
        check(!frame_irq, "R5 irq cleared on accept", frame_irq, 0);
        wait_frame_end();

        // R6 R7 frame request and host request in the middle of a frame
        sample_idx = 0;
        @(negedge clk); frame_req = 1'b1;
        @(negedge clk); frame_req = 1'b0;
        repeat (50) @(negedge clk);
        frame_req = 1'b1;
        @(negedge clk); frame_req = 1'b0;
        host_req = 1'b1; host_we = 1'b1; host_addr = 8'h05; host_wdata = 16'hBEEF;
        begin
            bit early = 1'b0;
            while (scan_busy) begin
                if (!host_en_n) early = 1'b1;
                @(negedge clk);
            end
            check(!early, "R7 no grant mid-frame", early, 0);
        end
        check(frame_irq, "R5 irq at frame end", frame_irq, 1);
        check(sample_idx == FLEN, "R2 frame length", sample_idx, FLEN);
        while (!host_done) @(negedge clk);
        check(!scan_busy && !host_en_n, "R7 host served after frame", {scan_busy, host_en_n}, 0);
        host_req = 1'b0; shadow[8'h05] = 16'hBEEF;
        repeat (20) @(negedge clk);
        check(!scan_busy && frame_irq, "R6 mid-frame request ignored", {scan_busy, frame_irq}, 1);

        // R10 host and frame request together
        sample_idx = 0;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 8'h00; host_wdata = 16'h1234;
        frame_req = 1'b1;
        @(negedge clk); frame_req = 1'b0;
        while (!host_done) @(negedge clk);
        check(!scan_busy, "R10 host before frame", scan_busy, 0);
        host_req = 1'b0; shadow[0] = 16'h1234;
        @(negedge clk);
        check(!scan_busy, "R10 idle gap", scan_busy, 0);
        @(negedge clk);
        check(scan_busy, "R10 pending frame starts", scan_busy, 1);
        check(!frame_irq, "R5 irq low at scan start", frame_irq, 0);
        wait_frame_end();

        // R10 frame request during a host access
        sample_idx = 0;
        @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_addr = 8'h3F; host_wdata = 16'h5678;
        repeat (3) @(negedge clk);
        frame_req = 1'b1;
        @(negedge clk); frame_req = 1'b0;
        while (!host_done) @(negedge clk);
        host_req = 1'b0; shadow[8'h3F] = 16'h5678;
        repeat (2) @(negedge clk);
        check(scan_busy, "R10 frame kept during host access", scan_busy, 1);
        wait_frame_end();

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule